// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Shoot-Through Interlock

This block turns a pulse-width-modulated stream and a half-cycle polarity signal into the four gate enables of a full bridge. The result is a three-level output across the load: positive, zero or negative. The bridge has two legs, and each leg has a high switch and a low switch. The polarity leg (S1 high, S2 low) changes state once per half cycle of the fundamental and chooses the sign of the output. The amplitude leg (S3 high, S4 low) follows the PWM pattern. The output is positive when S1 and S4 conduct and negative when S2 and S3 conduct. When both high switches or both low switches conduct, the load is shorted and the output is zero.

Each leg is driven by a true request and a complementary request, so the block takes four request pins. A leg whose two requests are both high is asking for shoot-through. The block refuses such a request and flags it. Every switch turn-on waits for a programmable off interval, counted in clock cycles, after its partner has turned off. A polarity change waits until the PWM pulse is inactive, so the bridge never reverses in the middle of a pulse.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While reset is high, all four gate enables and the fault flag are low.
- R2: The two switches of one leg are never enabled in the same cycle: not S1 with S2, and not S3 with S4.
- R3: A leg's switch never rises unless both switches of that leg were off for at least `dead_cnt` preceding cycles. When the request moves from one switch of a leg to the other and is then held, the rising switch goes high exactly `dead_cnt`+1 cycles after its partner went low.
- R4: If both requests of a leg are high (pwm_in and pwm_n_in for the amplitude leg, pol_in and pol_n_in for the polarity leg), both switches of that leg go off and fault goes high on the second clock edge after the request is applied. Fault stays high while the request is held and goes low two edges after the request is removed.
- R5: With positive polarity latched (pol_in=1, pol_n_in=0) and an active pulse (pwm_in=1, pwm_n_in=0), the bridge settles to S1 and S4 on. Gates follow a request change two clock edges later when the off interval allows.
- R6: With positive polarity and an inactive pulse (pwm_in=0, pwm_n_in=1), the bridge settles to S1 and S3 on, which is the zero state.
- R7: With negative polarity (pol_in=0, pol_n_in=1), an active pulse gives S2 and S3 on, and an inactive pulse gives S2 and S4 on.
- R8: A polarity input change is not taken while pwm_in is high. It is taken on the first edge at which pwm_in is low.
- R9: After reset is released, no gate rises until at least `dead_cnt` cycles have passed with all gates off.
- R10: If both requests of a leg are low, that leg stays off and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM pulse request, active high |
| pwm_n_in | input | 1 | Complementary PWM request |
| pol_in | input | 1 | Positive half-cycle request |
| pol_n_in | input | 1 | Negative half-cycle request |
| dead_cnt | input | DT_W | Off interval in clock cycles |
| gate_s1 | output | 1 | Polarity leg, high switch |
| gate_s2 | output | 1 | Polarity leg, low switch |
| gate_s3 | output | 1 | Amplitude leg, high switch |
| gate_s4 | output | 1 | Amplitude leg, low switch |
| fault | output | 1 | Forbidden request seen on either leg |

## Verification
A wrong off-interval count shows up at the ports on the first switch-over after it goes wrong. The partner gate rises one or more cycles early or late, and the bench measures that gap against `dead_cnt`+1 for every value in a sweep that runs from zero to the maximum. A corrupted polarity latch or leg mapping shows as the wrong pair of gates once the bench's settle interval has passed. A missed interlock shows in the very sample where both gates of a leg are high. A fault path that is off by one cycle or stuck shows at the fixed second-edge sample.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_req_t;

  localparam int NUM_LEGS = 2;
  localparam int LEG_POL  = 0;  // S1 high, S2 low
  localparam int LEG_AMP  = 1;  // S3 high, S4 low
endpackage

// File: rtl/hb_in_stage.sv
module hb_in_stage
  import hb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pwm_in,
  input  logic                      pwm_n_in,
  input  logic                      pol_in,
  input  logic                      pol_n_in,
  output leg_req_t [NUM_LEGS-1:0]   req_o
);
  logic     pwm_r, pwm_n_r;
  leg_req_t pol_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_r   <= 1'b0;
      pwm_n_r <= 1'b0;
      pol_eff <= '0;
    end else begin
      pwm_r   <= pwm_in;
      pwm_n_r <= pwm_n_in;
      // polarity is only taken while the incoming pulse is inactive
      if (!pwm_in) begin
        pol_eff.hi <= pol_in;
        pol_eff.lo <= pol_n_in;
      end
    end
  end

  always_comb begin
    req_o[LEG_POL] = pol_eff;
    // positive half: pulse drives low switch (S4), negative half: high switch (S3)
    req_o[LEG_AMP].hi = pol_eff.hi ? pwm_n_r : pwm_r;
    req_o[LEG_AMP].lo = pol_eff.hi ? pwm_r   : pwm_n_r;
  end

  // R8
  pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pol_eff) |-> !pwm_r);
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  leg_req_t        req,
  input  logic [DT_W-1:0] dead,
  output logic            gate_hi,
  output logic            gate_lo,
  output logic            forbid
);
  localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

  logic [DT_W-1:0] off_cnt;
  logic            off_ok;
  logic            hi_nxt, lo_nxt;

  always_comb begin
    forbid = req.hi & req.lo;
    off_ok = (off_cnt >= dead);
    hi_nxt = req.hi & ~req.lo & (gate_hi | (~gate_lo & off_ok));
    lo_nxt = req.lo & ~req.hi & (gate_lo | (~gate_hi & off_ok));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      off_cnt <= '0;
    end else begin
      gate_hi <= hi_nxt;
      gate_lo <= lo_nxt;
      if (gate_hi | gate_lo)
        off_cnt <= '0;
      else if (off_cnt != CNT_MAX)
        off_cnt <= off_cnt + 1'b1;
    end
  end

  // R2
  shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));
  // R3
  hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) |-> !$past(gate_lo));
  // R3
  lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo) |-> !$past(gate_hi));
  // R4
  forbid_off_chk: assert property (@(posedge clk) disable iff (rst)
    forbid |=> (!gate_hi && !gate_lo));
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hb_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_in,
  input  logic            pwm_n_in,
  input  logic            pol_in,
  input  logic            pol_n_in,
  input  logic [DT_W-1:0] dead_cnt,
  output logic            gate_s1,
  output logic            gate_s2,
  output logic            gate_s3,
  output logic            gate_s4,
  output logic            fault
);
  leg_req_t [NUM_LEGS-1:0] req;
  logic     [NUM_LEGS-1:0] g_hi, g_lo, forbid;

  hb_in_stage u_in (
    .clk      (clk),
    .rst      (rst),
    .pwm_in   (pwm_in),
    .pwm_n_in (pwm_n_in),
    .pol_in   (pol_in),
    .pol_n_in (pol_n_in),
    .req_o    (req)
  );

  for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
    hb_leg #(.DT_W(DT_W)) u_leg (
      .clk     (clk),
      .rst     (rst),
      .req     (req[i]),
      .dead    (dead_cnt),
      .gate_hi (g_hi[i]),
      .gate_lo (g_lo[i]),
      .forbid  (forbid[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) fault <= 1'b0;
    else     fault <= |forbid;
  end

  assign gate_s1 = g_hi[LEG_POL];
  assign gate_s2 = g_lo[LEG_POL];
  assign gate_s3 = g_hi[LEG_AMP];
  assign gate_s4 = g_lo[LEG_AMP];

  // R4
  fault_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|forbid) |=> fault);
  // R2
  bridge_short_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_s1 && gate_s2) && !(gate_s3 && gate_s4));
endmodule

// File: tb/hbridge_gate_seq_tb.sv
module hbridge_gate_seq_tb;
  localparam int DT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm = 1'b0, pwm_n = 1'b0, pol = 1'b0, pol_n = 1'b0;
  logic [DT_W-1:0] dead = '0;
  logic s1, s2, s3, s4, fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit exact_en = 1'b0;
  int run [2];
  bit last_hi [2], last_lo [2], prev_hi [2], prev_lo [2];
  bit first_rise;

  always #4 clk = ~clk;

  hbridge_gate_seq #(.DT_W(DT_W)) u_dut (
    .clk(clk), .rst(rst), .pwm_in(pwm), .pwm_n_in(pwm_n),
    .pol_in(pol), .pol_n_in(pol_n), .dead_cnt(dead),
    .gate_s1(s1), .gate_s2(s2), .gate_s3(s3), .gate_s4(s4), .fault(fault)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // continuous monitor of interlock and spacing
  always @(negedge clk) begin
    logic [1:0] h, l;
    h = {s3, s1};
    l = {s4, s2};
    if (rst) begin
      first_rise = 1'b1;
      for (int i = 0; i < 2; i++) begin
        run[i] = 0; last_hi[i] = 0; last_lo[i] = 0; prev_hi[i] = 0; prev_lo[i] = 0;
      end
    end else if (!done) begin
      for (int i = 0; i < 2; i++) begin
        chk(!(h[i] && l[i]), "R2", "leg both on", int'({h[i], l[i]}), 0);
        if ((h[i] && !prev_hi[i]) || (l[i] && !prev_lo[i])) begin
          chk(run[i] >= int'(dead), first_rise ? "R9" : "R3", "off cycles before rise",
              run[i], int'(dead));
          first_rise = 1'b0;
          if (exact_en && ((h[i] && last_lo[i]) || (l[i] && last_hi[i])))
            chk(run[i] == int'(dead) + 1, "R3", "exact switch-over gap", run[i], int'(dead) + 1);
        end
        if (!h[i] && !l[i]) run[i]++;
        else run[i] = 0;
        if (h[i]) begin last_hi[i] = 1; last_lo[i] = 0; end
        else if (l[i]) begin last_lo[i] = 1; last_hi[i] = 0; end
        prev_hi[i] = h[i];
        prev_lo[i] = l[i];
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_gates(input logic [3:0] exp, input string req);
    chk({s1, s2, s3, s4} == exp, req, "gates {s1,s2,s3,s4}", int'({s1, s2, s3, s4}), int'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    hold(3);
    chk({s1, s2, s3, s4, fault} == 5'b0, "R1", "outputs in reset", int'({s1, s2, s3, s4, fault}), 0);
    rst = 1'b0;
  endtask

  initial begin
    int dl [8] = '{0, 1, 2, 3, 5, 8, 13, 255};
    for (int k = 0; k < 8; k++) begin
      int hl;
      hl = dl[k] + 20;
      exact_en = 1'b0;
      dead = DT_W'(dl[k]);
      pol = 1; pol_n = 0; pwm = 0; pwm_n = 1;
      do_reset();
      exact_en = 1'b1;
      hold(hl); expect_gates(4'b1010, "R6");
      chk(fault == 0, "R6", "no fault", int'(fault), 0);
      pwm = 1; pwm_n = 0; hold(hl); expect_gates(4'b1001, "R5");
      pwm = 0; pwm_n = 1; hold(hl); expect_gates(4'b1010, "R6");
      pol = 0; pol_n = 1; hold(hl); expect_gates(4'b0101, "R7");
      pwm = 1; pwm_n = 0; hold(hl); expect_gates(4'b0110, "R7");
      // polarity change during an active pulse is held back
      pol = 1; pol_n = 0; hold(hl); expect_gates(4'b0110, "R8");
      pwm = 0; pwm_n = 1; hold(hl); expect_gates(4'b1010, "R8");
    end

    // forbidden and empty requests with a short off interval
    exact_en = 1'b0;
    dead = DT_W'(3);
    pol = 1; pol_n = 0; pwm = 0; pwm_n = 1;
    do_reset();
    hold(30);
    pwm = 1; pwm_n = 1;
    hold(1);
    chk(fault == 0, "R4", "fault one edge after request", int'(fault), 0);
    hold(1);
    chk(fault == 1, "R4", "fault on second edge", int'(fault), 1);
    expect_gates(4'b1000, "R4");
    hold(10);
    chk(fault == 1, "R4", "fault while held", int'(fault), 1);
    pwm = 0; pwm_n = 1;
    hold(2);
    chk(fault == 0, "R4", "fault clears", int'(fault), 0);
    hold(30); expect_gates(4'b1010, "R4");
    pol = 1; pol_n = 1;
    hold(2);
    chk(fault == 1, "R4", "polarity leg fault", int'(fault), 1);
    chk({s1, s2} == 2'b00, "R4", "polarity leg off", int'({s1, s2}), 0);
    pol = 1; pol_n = 0;
    hold(30); expect_gates(4'b1010, "R4");
    pwm = 0; pwm_n = 0;
    hold(30); expect_gates(4'b1000, "R10");
    chk(fault == 0, "R10", "no fault on empty request", int'(fault), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule